// File: doc/BRIEF.md
# Two-Threshold Cross-Window Cluster Compressor

This block takes a detector matrix of 9-bit samples as a stream, one anode row at a time, with the time samples of a row arriving in ascending order. Two line buffers hold the two rows that came before the row now arriving. A row is judged while the row after it streams in. Each step builds a plus-shaped window of five samples: the centre, the samples just before and just after it in time, and the samples at the same time index in the rows above and below. Any window position outside the matrix reads as zero.

A centre is accepted when it clears a high threshold and at least one of its four neighbours clears a low threshold. Each accepted centre produces one 25-bit word that holds its row index, its time index and its amplitude. After the last input row has arrived, the block closes its input and evaluates that row against an all-zero row below it. It then pulses an end-of-event strobe and keeps the input closed for a fixed hold time, so that the buffering downstream can empty. The row length and the row count per event are set through configuration inputs that stay steady during an event.

Top module: `clusterCompressor2d`

## Requirements
- R1: The row length is `cfgLastTime`+1 samples (1 to 256). The time index in an output word is the zero-based position of the centre within its row.
- R2: An event is `cfgLastRow`+1 rows (1 to 256). The row index in an output word is the zero-based row of the centre.
- R3: A centre is reported only when its value is strictly greater than `thrHigh` and at least one of its four neighbours is strictly greater than `thrLow`. A value equal to a threshold does not pass it.
- R4: A neighbour before time 0, after the last time index, above row 0 or below the last row reads as zero.
- R5: Output word layout: bits [24:17] row index, [16:9] time index, [8:0] centre amplitude. `outValid` is high for exactly one cycle per accepted centre.
- R6: Words appear in row-major order. The word for centre (r,t) appears one cycle after sample t of row r+1 is accepted, or after the matching flush step for the last row.
- R7: Once the last sample of an event has been accepted, `inEnable` drops and the last row is evaluated over `cfgLastTime`+1 internal steps with a zero row below it.
- R8: `eventDone` is high for one cycle, in the same cycle as the word for the last centre (last row, last time) would appear. Every word of the event has appeared by that cycle.
- R9: `inEnable` is low in the `eventDone` cycle and for the 255 cycles after it, and is high in the next cycle. A sample is accepted only when `inValid` and `inEnable` are both high. `inValid` has no effect while `inEnable` is low.
- R10: Synchronous active-high reset makes `inEnable` high and `outValid` and `eventDone` low, and clears the row, time and hold counters, so that the next accepted sample is row 0, time 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLastTime | input | 8 | Samples per row minus one |
| cfgLastRow | input | 8 | Rows per event minus one |
| thrHigh | input | 9 | Centre threshold (strict) |
| thrLow | input | 9 | Neighbour threshold (strict) |
| inValid | input | 1 | Source offers a sample |
| inData | input | 9 | Sample value |
| inEnable | output | 1 | Block accepts samples |
| outValid | output | 1 | Cluster word valid |
| outWord | output | 25 | {row, time, amplitude} |
| eventDone | output | 1 | End-of-event pulse |

## Verification
The word for the bottom-right corner cluster and the end-of-event pulse come from the same flush step. Both therefore fall in one cycle. The bench sets up an event whose last centre passes only through its upper neighbour. It then requires `outValid` and `eventDone` together, with that word last in the comparison queue. The second pairing is the start of the hold time and continued attempts by the source: the bench keeps `inValid` high with junk data throughout flush and hold. It then confirms that `inEnable` stays low for exactly 256 cycles and that the next event's words match the arithmetic model exactly.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int SAMPLE_W = 9;
  localparam int IDX_W    = 8;
  localparam int WORD_W   = 2 * IDX_W + SAMPLE_W;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic             step;      // a window position is processed this cycle
    logic             evalEn;    // the centre row exists (not the fill row)
    logic             firstCol;  // left neighbour is outside the matrix
    logic             lastCol;   // right neighbour is outside the matrix
    logic             topZero;   // upper neighbour is outside the matrix
    logic             botZero;   // flush step: lower row is all zero
    logic [IDX_W-1:0] timeIdx;
    logic [IDX_W-1:0] centerRow;
  } ctrlStrobes_t;
endpackage

// File: rtl/ccLineBuf.sv
module ccLineBuf #(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 256,
  parameter int NUM_RD = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr [NUM_RD],
  output logic [WIDTH-1:0] rdData [NUM_RD]
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // reads see the value held before this cycle's write
  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rdData[k] = mem[rdAddr[k]];
  end
endmodule

// File: rtl/ccControl.sv
module ccControl
  import cc_pkg::*;
#(
  parameter int HOLD_CYCLES = 256,
  localparam int HOLD_W     = $clog2(HOLD_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cfgLastTime,
  input  logic [IDX_W-1:0] cfgLastRow,
  input  logic             inValid,
  output logic             inEnable,
  output logic             eventDone,
  output ctrlStrobes_t     ctl
);
  typedef enum logic [1:0] {S_RUN, S_FLUSH, S_HOLD} state_t;

  state_t            state;
  logic [IDX_W:0]    rowCnt;   // row currently arriving; reaches cfgLastRow+1 in flush
  logic [IDX_W-1:0]  timeCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              lastCol;
  logic              lastInRow;
  logic              step;

  assign inEnable  = (state == S_RUN);
  assign step      = (inEnable && inValid) || (state == S_FLUSH);
  assign lastCol   = (timeCnt == cfgLastTime);
  assign lastInRow = (rowCnt[IDX_W-1:0] == cfgLastRow);

  always_comb begin
    ctl           = '0;
    ctl.step      = step;
    ctl.evalEn    = step && (rowCnt != '0);
    ctl.firstCol  = (timeCnt == '0);
    ctl.lastCol   = lastCol;
    ctl.topZero   = (rowCnt == (IDX_W+1)'(1));
    ctl.botZero   = (state == S_FLUSH);
    ctl.timeIdx   = timeCnt;
    ctl.centerRow = IDX_W'(rowCnt - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_RUN;
      rowCnt    <= '0;
      timeCnt   <= '0;
      holdCnt   <= '0;
      eventDone <= 1'b0;
    end else begin
      eventDone <= 1'b0;
      unique case (state)
        S_RUN: begin
          if (step) begin
            if (lastCol) begin
              timeCnt <= '0;
              rowCnt  <= rowCnt + 1'b1;
              if (lastInRow) state <= S_FLUSH;
            end else begin
              timeCnt <= timeCnt + 1'b1;
            end
          end
        end
        S_FLUSH: begin
          if (lastCol) begin
            timeCnt   <= '0;
            rowCnt    <= '0;
            holdCnt   <= '0;
            eventDone <= 1'b1;
            state     <= S_HOLD;
          end else begin
            timeCnt <= timeCnt + 1'b1;
          end
        end
        default: begin
          if (holdCnt == HOLD_W'(HOLD_CYCLES - 1)) state <= S_RUN;
          else holdCnt <= holdCnt + 1'b1;
        end
      endcase
    end
  end

  p_done_blocks_input_r9: assert property (@(posedge clk) disable iff (rst)
    eventDone |-> !inEnable);

  p_done_follows_flush_r8: assert property (@(posedge clk) disable iff (rst)
    eventDone |-> $past(state == S_FLUSH));
endmodule

// File: rtl/ccDatapath.sv
module ccDatapath
  import cc_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        ctl,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic [SAMPLE_W-1:0] thrHigh,
  input  logic [SAMPLE_W-1:0] thrLow,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord
);
  logic [AW-1:0]       midAddr [2];
  logic [SAMPLE_W-1:0] midData [2];
  logic [AW-1:0]       topAddr [1];
  logic [SAMPLE_W-1:0] topData [1];
  logic [SAMPLE_W-1:0] lowerIn, leftReg;
  logic [SAMPLE_W-1:0] center, left, right, up, down;
  logic                accept;

  assign midAddr[0] = AW'(ctl.timeIdx);
  assign midAddr[1] = AW'(ctl.timeIdx + 1'b1);
  assign topAddr[0] = AW'(ctl.timeIdx);
  assign lowerIn    = ctl.botZero ? '0 : inData;

  // row above the centre; refilled from the centre row as it is consumed
  ccLineBuf #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH), .NUM_RD(1)) uTopRow (
    .clk(clk), .wrEn(ctl.step), .wrAddr(AW'(ctl.timeIdx)),
    .wrData(midData[0]), .rdAddr(topAddr), .rdData(topData));

  // centre row; two reads give the centre and its right neighbour
  ccLineBuf #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH), .NUM_RD(2)) uMidRow (
    .clk(clk), .wrEn(ctl.step), .wrAddr(AW'(ctl.timeIdx)),
    .wrData(lowerIn), .rdAddr(midAddr), .rdData(midData));

  assign center = midData[0];
  assign left   = ctl.firstCol ? '0 : leftReg;
  assign right  = ctl.lastCol  ? '0 : midData[1];
  assign up     = ctl.topZero  ? '0 : topData[0];
  assign down   = lowerIn;

  assign accept = (center > thrHigh) &&
                  ((left > thrLow) || (right > thrLow) || (up > thrLow) || (down > thrLow));

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outWord  <= '0;
      leftReg  <= '0;
    end else begin
      outValid <= ctl.evalEn && accept;
      if (ctl.step) leftReg <= center;
      if (ctl.evalEn && accept) outWord <= {ctl.centerRow, ctl.timeIdx, center};
    end
  end

  p_amp_over_high_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outWord[SAMPLE_W-1:0] > $past(thrHigh)));

  p_time_ascends_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(outValid) && (outWord[WORD_W-1 -: IDX_W] == $past(outWord[WORD_W-1 -: IDX_W])))
    |-> (outWord[SAMPLE_W +: IDX_W] > $past(outWord[SAMPLE_W +: IDX_W])));
endmodule

// File: rtl/clusterCompressor2d.sv
module clusterCompressor2d
  import cc_pkg::*;
#(
  parameter int HOLD_CYCLES = 256,
  parameter int DEPTH       = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    cfgLastTime,
  input  logic [IDX_W-1:0]    cfgLastRow,
  input  logic [SAMPLE_W-1:0] thrHigh,
  input  logic [SAMPLE_W-1:0] thrLow,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                inEnable,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord,
  output logic                eventDone
);
  ctrlStrobes_t ctl;

  ccControl #(.HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk(clk), .rst(rst), .cfgLastTime(cfgLastTime), .cfgLastRow(cfgLastRow),
    .inValid(inValid), .inEnable(inEnable), .eventDone(eventDone), .ctl(ctl));

  ccDatapath #(.DEPTH(DEPTH)) uPath (
    .clk(clk), .rst(rst), .ctl(ctl), .inData(inData),
    .thrHigh(thrHigh), .thrLow(thrLow), .outValid(outValid), .outWord(outWord));
endmodule

// File: tb/tb_clusterCompressor2d.sv
`timescale 1ns/1ps
module tb_clusterCompressor2d;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfgLastTime = 8'd4, cfgLastRow = 8'd3;
  logic [8:0]  thrHigh = 9'd0, thrLow = 9'd0;
  logic        inValid = 1'b0;
  logic [8:0]  inData = 9'd0;
  logic        inEnable, outValid, eventDone;
  logic [24:0] outWord;

  clusterCompressor2d dut (
    .clk(clk), .rst(rst), .cfgLastTime(cfgLastTime), .cfgLastRow(cfgLastRow),
    .thrHigh(thrHigh), .thrLow(thrLow), .inValid(inValid), .inData(inData),
    .inEnable(inEnable), .outValid(outValid), .outWord(outWord), .eventDone(eventDone));

  always #10 clk = ~clk;

  int          nChecks = 0, nFails = 0;
  logic [8:0]  mat [8][256];
  logic [24:0] expWord [2048];
  int          expCnt = 0, seenIdx = 0, holdCnt = 0, coincCnt = 0;
  bit          doneFlag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] pat(int p, int r, int t, int M, int N, logic [8:0] h, logic [8:0] l);
    case (p)
      0: return 9'((r * 97 + t * 41 + r * t * 13 + 7) % 512);
      1: return ((r == 0 && t == 0) || (r == M-1 && t == N-1)) ? 9'd300 : 9'd0;
      2: begin
        if (r == 0 && t == 0) return 9'd300;
        if (r == 0 && t == 1) return 9'd2;
        if (r == M-1 && t == N-1) return 9'd511;
        if (r == M-2 && t == N-1) return 9'd2;
        return 9'd0;
      end
      default: case ((r * 3 + t) % 4)
        0: return h;
        1: return h + 9'd1;
        2: return l;
        default: return l + 9'd1;
      endcase
    endcase
  endfunction

  // arithmetic reference: R1..R5 word contents, R6 row-major order
  task automatic buildExpected(input int M, input int N);
    logic [8:0] c, lf, rt, up, dn;
    expCnt = 0;
    for (int r = 0; r < M; r++)
      for (int t = 0; t < N; t++) begin
        c  = mat[r][t];
        lf = (t > 0)   ? mat[r][t-1] : 9'd0;
        rt = (t < N-1) ? mat[r][t+1] : 9'd0;
        up = (r > 0)   ? mat[r-1][t] : 9'd0;
        dn = (r < M-1) ? mat[r+1][t] : 9'd0;
        if (c > thrHigh && (lf > thrLow || rt > thrLow || up > thrLow || dn > thrLow)) begin
          expWord[expCnt] = {8'(r), 8'(t), c};
          expCnt++;
        end
      end
  endtask

  task automatic offer(input logic [8:0] v, input bit junk);
    forever begin
      @(negedge clk);
      if (inEnable) break;
      inValid = junk;          // R9: attempts while closed must be ignored
      inData  = 9'h1FF;
    end
    inValid = 1'b1;
    inData  = v;
  endtask

  task automatic runEvent(input int M, input int N, input int p,
                          input logic [8:0] h, input logic [8:0] l, input bit gaps);
    cfgLastRow  = 8'(M - 1);
    cfgLastTime = 8'(N - 1);
    thrHigh = h;
    thrLow  = l;
    for (int r = 0; r < M; r++)
      for (int t = 0; t < N; t++) mat[r][t] = pat(p, r, t, M, N, h, l);
    buildExpected(M, N);
    seenIdx  = 0;
    doneFlag = 0;
    for (int r = 0; r < M; r++)
      for (int t = 0; t < N; t++) begin
        offer(mat[r][t], 1'b1);
        if (gaps && (t % 2 == 1)) begin
          @(negedge clk);
          inValid = 1'b0;
          inData  = 9'h155;
        end
      end
    @(negedge clk);
    inValid = 1'b1;
    inData  = 9'h1FF;
    chk(!inEnable, "R7 input closed during flush", 32'(inEnable), 32'd0);
    wait (doneFlag);
  endtask

  // monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      holdCnt = 0;
    end else begin
      if (outValid) begin
        if (seenIdx < expCnt)
          chk(outWord == expWord[seenIdx], "R3/R5/R6 cluster word", 32'(outWord), 32'(expWord[seenIdx]));
        else
          chk(1'b0, "R3/R4 unexpected cluster word", 32'(outWord), 32'h0);
        seenIdx++;
      end
      if (holdCnt > 0) begin
        if (holdCnt < 256) begin
          chk(!inEnable, "R9 input held closed", 32'(inEnable), 32'd0);
          chk(!eventDone, "R8 single-cycle done", 32'(eventDone), 32'd0);
          holdCnt++;
        end else begin
          chk(inEnable, "R9 input reopens after hold", 32'(inEnable), 32'd1);
          holdCnt = 0;
        end
      end
      if (eventDone) begin
        chk(seenIdx == expCnt, "R8 all words by done", 32'(seenIdx), 32'(expCnt));
        chk(!inEnable, "R9 closed in done cycle", 32'(inEnable), 32'd0);
        if (outValid) coincCnt++;
        holdCnt  = 1;
        doneFlag = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(inEnable == 1'b1, "R10 inEnable after reset", 32'(inEnable), 32'd1);
    chk(outValid == 1'b0, "R10 outValid after reset", 32'(outValid), 32'd0);
    chk(eventDone == 1'b0, "R10 eventDone after reset", 32'(eventDone), 32'd0);

    runEvent(4, 5, 0, 9'd200, 9'd100, 1'b0);   // R1 R2 R3 generic pattern
    runEvent(4, 5, 3, 9'd50,  9'd20,  1'b1);   // R3 equality at thresholds, gaps

    // R10: interrupt a partial row with reset, then a fresh event must be exact
    for (int t = 0; t < 3; t++) offer(9'd400, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(inEnable == 1'b1, "R10 inEnable after mid-event reset", 32'(inEnable), 32'd1);

    runEvent(3, 6, 1, 9'd100, 9'd0,  1'b0);    // R4 isolated corners: no words
    runEvent(3, 6, 2, 9'd100, 9'd1,  1'b0);    // R4 R8 corner words, last coincides
    runEvent(2, 256, 0, 9'd300, 9'd150, 1'b0); // R1 maximum row length
    runEvent(1, 3, 0, 9'd10, 9'd5, 1'b0);      // R2 R4 single row, both borders zero
    runEvent(8, 7, 0, 9'd250, 9'd200, 1'b0);   // R2 more rows

    chk(coincCnt >= 1, "R8 last word with done", 32'(coincCnt), 32'd1);
    wait (holdCnt == 0);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule